// File: doc/BRIEF.md
# Ring-based receive descriptor fill engine

This block takes received frames from a byte-wide streaming input and places each one into a software-owned buffer. Buffers are described by a small circular table held inside the block. Each table entry carries a status halfword, a length halfword and a buffer pointer. Software hands an entry to the engine by setting its EMPTY flag. The engine then writes the frame bytes to an external byte-addressed buffer port, starting at that entry's pointer. After the last byte it writes the length and the outcome into the entry, gives the entry back by clearing EMPTY, and moves to the next entry.

Software reaches every control field and every table entry through one register port. The port has a single-cycle write strobe and a combinational read. Software sets:
- the index at which the table starts, which is also where the engine goes after an entry carrying WRAP;
- a per-buffer byte limit;
- a request to stop at the next frame boundary.

A frame that finds its entry still owned by software raises a busy event and parks the engine. While parked, the engine swallows whole frames. It leaves that state only when software issues a clear-halt command.

Top module: `rxbd_ring_rx`

## Requirements
- R1: A frame is stored only into the current entry when that entry's status bit 15 (EMPTY) is set. On completion the engine writes status with bit 15 cleared and bit 11 (LAST) set. The status word is read at register address 0x80+2*i, status in bits 31:16 and length in bits 15:0. The pointer is read at 0x81+2*i.
- R2: After filling an entry whose status bit 13 (WRAP) is set, the next entry used is the table base index, and bit 13 is kept in the written status. Otherwise the next entry is the following index, wrapping modulo the table size. Writing the base register (address 0x02) also makes that index the current entry.
- R3: Byte k of a frame (k counting from 0) is written to buffer address pointer+k, in arrival order. No address at or beyond pointer+stored length is written.
- R4: The stored length is the count of all bytes the stream delivered for the frame, including its trailing 4-byte check sequence.
- R5: Bytes beyond the limit in the register at address 0x03 are discarded. The length is then the limit, and status bit 0 (TRUNC) is set. A frame of exactly the limit is not flagged.
- R6: A frame with the stream error flag on any byte gets status bit 1 (RXERR). The error group is bits 1:0, and a frame is good exactly when that group is zero.
- R7: A frame that meets an entry without EMPTY does three things. It sets bit 0 of the event register (address 0x00). It makes bit 0 of the receive status register (address 0x01) read 1 (halted). It is dropped with no buffer write and no table change.
- R8: While halted, further frames are dropped. Writing 1 to bit 0 of address 0x01 resumes reception at the next frame boundary. Event bits are cleared only by writing 1 to them; writing 0 leaves them.
- R9: Setting bit 0 of address 0x04 requests a graceful stop. A frame in progress is completed and stored, then event bit 1 is set and the stream input is not accepted until the bit is cleared.
- R10: After reset the stream ready output is low, both event bits are 0, the halted flag is 0 and the current entry is index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of the frame |
| s_err | input | 1 | Receive error on this byte |
| s_ready | output | 1 | Engine accepts a stream byte |
| sw_wr | input | 1 | Register write strobe |
| sw_addr | input | 8 | Register address |
| sw_wdata | input | 32 | Register write data |
| sw_rdata | output | 32 | Register read data (combinational) |
| buf_we | output | 1 | Buffer byte write enable |
| buf_addr | output | BUF_AW | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |

## Verification
A frame of N bytes spends 1 cycle claiming its entry, then N accepted cycles, then 1 write-back cycle. The table entry changes at the edge that ends the write-back. Each buffer byte appears on the port one cycle after its stream handshake. Event bits show up one edge after the cycle that raised them. Resuming after clear-halt takes two edges. The bench therefore reads table entries and events only after at least three falling edges have passed since the last beat. It records buffer writes on every falling edge, so the buffer image and the write count are complete before any comparison is made.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
    localparam int LEN_W     = 16;
    localparam int BIT_EMPTY = 15;
    localparam int BIT_WRAP  = 13;
    localparam int BIT_LAST  = 11;
    localparam int BIT_RXERR = 1;
    localparam int BIT_TRUNC = 0;

    localparam logic [6:0] REG_EVENT  = 7'h00;
    localparam logic [6:0] REG_RSTAT  = 7'h01;
    localparam logic [6:0] REG_BASE   = 7'h02;
    localparam logic [6:0] REG_MAXLEN = 7'h03;
    localparam logic [6:0] REG_CTRL   = 7'h04;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RECV,
        S_WB,
        S_HALT,
        S_STOP
    } fill_state_e;
endpackage

// File: rtl/rxbd_desc_table.sv
module rxbd_desc_table
    import rxbd_pkg::*;
#(
    parameter int NDESC  = 8,
    parameter int BUF_AW = 16,
    parameter int IDX_W  = $clog2(NDESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic              sw_hi,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       sw_rdata,
    input  logic [IDX_W-1:0]  eng_idx,
    output logic [15:0]       eng_status,
    output logic [BUF_AW-1:0] eng_ptr,
    input  logic              eng_we,
    input  logic [15:0]       eng_wr_status,
    input  logic [LEN_W-1:0]  eng_wr_len
);
    typedef struct packed {
        logic [NDESC-1:0][15:0]       st;
        logic [NDESC-1:0][LEN_W-1:0]  len;
        logic [NDESC-1:0][BUF_AW-1:0] ptr;
    } tbl_t;

    tbl_t q, d;

    always_comb begin
        d = q;
        if (sw_we) begin
            if (sw_hi) begin
                d.ptr[sw_idx] = sw_wdata[BUF_AW-1:0];
            end else begin
                d.st[sw_idx]  = sw_wdata[31:16];
                d.len[sw_idx] = sw_wdata[LEN_W-1:0];
            end
        end
        // engine write-back has priority over a software write
        if (eng_we) begin
            d.st[eng_idx]  = eng_wr_status;
            d.len[eng_idx] = eng_wr_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign eng_status = q.st[eng_idx];
    assign eng_ptr    = q.ptr[eng_idx];
    assign sw_rdata   = sw_hi ? 32'(q.ptr[sw_idx]) : {q.st[sw_idx], q.len[sw_idx]};

    // R1: the engine hands back only an entry it owned
    a_r1_claim_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> q.st[eng_idx][BIT_EMPTY]);
    // R1: a completed entry is returned to software
    a_r1_returned: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && !(sw_we && !sw_hi && sw_idx == eng_idx)) |=> !q.st[$past(eng_idx)][BIT_EMPTY]);
endmodule

// File: rtl/rxbd_ctl_regs.sv
module rxbd_ctl_regs
    import rxbd_pkg::*;
#(
    parameter int NDESC      = 8,
    parameter int MAXLEN_RST = 1536,
    parameter int IDX_W      = $clog2(NDESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr,
    input  logic [7:0]       sw_addr,
    input  logic [31:0]      sw_wdata,
    output logic [31:0]      sw_rdata,
    output logic             desc_we,
    output logic [IDX_W-1:0] desc_idx,
    output logic             desc_hi,
    input  logic [31:0]      desc_rdata,
    input  logic             halted,
    input  logic             busy_set,
    input  logic             stop_set,
    output logic [LEN_W-1:0] maxlen,
    output logic [IDX_W-1:0] base_idx,
    output logic             stop_req,
    output logic             clr_halt,
    output logic             base_load,
    output logic [IDX_W-1:0] base_val
);
    typedef struct packed {
        logic [IDX_W-1:0] base;
        logic [LEN_W-1:0] maxlen;
        logic             stop;
        logic             ev_busy;
        logic             ev_stop;
    } regs_t;

    regs_t q, d;

    logic reg_wr, desc_sel, ev_wr;

    assign reg_wr   = sw_wr && !sw_addr[7];
    assign desc_sel = sw_addr[7] && (32'(sw_addr[6:1]) < NDESC);
    assign desc_we  = sw_wr && desc_sel;
    assign desc_idx = sw_addr[IDX_W:1];
    assign desc_hi  = sw_addr[0];
    assign ev_wr    = reg_wr && (sw_addr[6:0] == REG_EVENT);

    always_comb begin
        d = q;
        if (reg_wr) begin
            case (sw_addr[6:0])
                REG_EVENT: begin
                    if (sw_wdata[0]) d.ev_busy = 1'b0;
                    if (sw_wdata[1]) d.ev_stop = 1'b0;
                end
                REG_BASE:   d.base   = sw_wdata[IDX_W-1:0];
                REG_MAXLEN: d.maxlen = sw_wdata[LEN_W-1:0];
                REG_CTRL:   d.stop   = sw_wdata[0];
                default: ;
            endcase
        end
        if (busy_set) d.ev_busy = 1'b1;
        if (stop_set) d.ev_stop = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.maxlen <= LEN_W'(MAXLEN_RST);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        sw_rdata = '0;
        if (sw_addr[7]) begin
            if (desc_sel) sw_rdata = desc_rdata;
        end else begin
            case (sw_addr[6:0])
                REG_EVENT:  sw_rdata = {30'd0, q.ev_stop, q.ev_busy};
                REG_RSTAT:  sw_rdata = {31'd0, halted};
                REG_BASE:   sw_rdata = 32'(q.base);
                REG_MAXLEN: sw_rdata = 32'(q.maxlen);
                REG_CTRL:   sw_rdata = {31'd0, q.stop};
                default:    sw_rdata = '0;
            endcase
        end
    end

    assign maxlen    = q.maxlen;
    assign base_idx  = q.base;
    assign stop_req  = q.stop;
    assign clr_halt  = reg_wr && (sw_addr[6:0] == REG_RSTAT) && sw_wdata[0];
    assign base_load = reg_wr && (sw_addr[6:0] == REG_BASE);
    assign base_val  = sw_wdata[IDX_W-1:0];

    // R7: a busy indication from the engine is recorded
    a_r7_busy_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_set |=> q.ev_busy);
    // R8: the busy event stays until a 1 is written to it
    a_r8_busy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ev_busy && !(ev_wr && sw_wdata[0])) |=> q.ev_busy);
    // R8: writing 1 clears the busy event
    a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wr && sw_wdata[0] && !busy_set) |=> !q.ev_busy);
endmodule

// File: rtl/rxbd_fill_fsm.sv
module rxbd_fill_fsm
    import rxbd_pkg::*;
#(
    parameter int NDESC  = 8,
    parameter int BUF_AW = 16,
    parameter int IDX_W  = $clog2(NDESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    input  logic              s_err,
    output logic              s_ready,
    input  logic [LEN_W-1:0]  maxlen,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic              stop_req,
    input  logic              clr_halt,
    input  logic              base_load,
    input  logic [IDX_W-1:0]  base_val,
    output logic [IDX_W-1:0]  cur_idx,
    input  logic [15:0]       rd_status,
    input  logic [BUF_AW-1:0] rd_ptr,
    output logic              desc_we,
    output logic [15:0]       wr_status,
    output logic [LEN_W-1:0]  wr_len,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    output logic              busy_set,
    output logic              stop_set,
    output logic              halted
);
    typedef struct packed {
        fill_state_e       state;
        logic [IDX_W-1:0]  idx;
        logic [BUF_AW-1:0] ptr;
        logic [LEN_W-1:0]  cnt;
        logic              trunc;
        logic              err;
        logic              mid;
        logic              resume;
        logic              buf_we;
        logic [BUF_AW-1:0] buf_addr;
        logic [7:0]        buf_data;
    } fsm_t;

    fsm_t q, d;

    assign s_ready = (q.state == S_RECV) ||
                     ((q.state == S_HALT) && !(q.resume && !q.mid));

    always_comb begin
        d         = q;
        d.buf_we  = 1'b0;
        desc_we   = 1'b0;
        wr_status = '0;
        wr_len    = q.cnt;
        busy_set  = 1'b0;
        stop_set  = 1'b0;
        case (q.state)
            S_IDLE: begin
                if (stop_req) begin
                    d.state  = S_STOP;
                    stop_set = 1'b1;
                end else if (s_valid) begin
                    if (rd_status[BIT_EMPTY]) begin
                        d.state = S_RECV;
                        d.ptr   = rd_ptr;
                        d.cnt   = '0;
                        d.trunc = 1'b0;
                        d.err   = 1'b0;
                    end else begin
                        d.state  = S_HALT;
                        d.mid    = 1'b0;
                        d.resume = 1'b0;
                        busy_set = 1'b1;
                    end
                end
            end
            S_RECV: begin
                if (s_valid) begin
                    if (s_err) d.err = 1'b1;
                    if (q.cnt < maxlen) begin
                        d.buf_we   = 1'b1;
                        d.buf_addr = q.ptr + BUF_AW'(q.cnt);
                        d.buf_data = s_data;
                        d.cnt      = q.cnt + 1'b1;
                    end else begin
                        d.trunc = 1'b1;
                    end
                    if (s_last) d.state = S_WB;
                end
            end
            S_WB: begin
                desc_we = 1'b1;
                wr_status[BIT_WRAP]  = rd_status[BIT_WRAP];
                wr_status[BIT_LAST]  = 1'b1;
                wr_status[BIT_TRUNC] = q.trunc;
                wr_status[BIT_RXERR] = q.err;
                if (rd_status[BIT_WRAP])         d.idx = base_idx;
                else if (q.idx == IDX_W'(NDESC - 1)) d.idx = '0;
                else                                 d.idx = q.idx + 1'b1;
                if (stop_req) begin
                    d.state  = S_STOP;
                    stop_set = 1'b1;
                end else begin
                    d.state = S_IDLE;
                end
            end
            S_HALT: begin
                if (q.resume && !q.mid) begin
                    d.state  = S_IDLE;
                    d.resume = 1'b0;
                end else begin
                    if (s_valid) d.mid = !s_last;
                    if (clr_halt) d.resume = 1'b1;
                end
            end
            S_STOP: begin
                if (!stop_req) d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
        if (base_load && (q.state != S_RECV) && (q.state != S_WB)) d.idx = base_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cur_idx   = q.idx;
    assign buf_we    = q.buf_we;
    assign buf_addr  = q.buf_addr;
    assign buf_wdata = q.buf_data;
    assign halted    = (q.state == S_HALT);

    // R5: the written-back length never exceeds the buffer limit
    a_r5_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we |-> (wr_len <= maxlen));
    // R3: buffer writes stay inside the claimed buffer window
    a_r3_write_window: assert property (@(posedge clk) disable iff (!rst_n)
        q.buf_we |-> (LEN_W'(q.buf_addr - q.ptr) < maxlen));
    // R7: nothing is written while parked
    a_r7_no_write_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_HALT) |-> (!q.buf_we && !desc_we));
    // R2: an entry with WRAP sends the engine back to the base index
    a_r2_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_we && wr_status[BIT_WRAP]) |=> (q.idx == $past(base_idx)));
    // R9: a stop request seen at write-back blocks further input
    a_r9_stop_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == S_WB) && stop_req) |=> !s_ready);
endmodule

// File: rtl/rxbd_ring_rx.sv
module rxbd_ring_rx
    import rxbd_pkg::*;
#(
    parameter int NDESC      = 8,
    parameter int BUF_AW     = 16,
    parameter int MAXLEN_RST = 1536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    input  logic              s_err,
    output logic              s_ready,
    input  logic              sw_wr,
    input  logic [7:0]        sw_addr,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       sw_rdata,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [7:0]        buf_wdata
);
    localparam int IDX_W = (NDESC > 1) ? $clog2(NDESC) : 1;

    logic             desc_we, desc_hi;
    logic [IDX_W-1:0] desc_idx;
    logic [31:0]      desc_rdata;
    logic             halted, busy_set, stop_set;
    logic [LEN_W-1:0] maxlen;
    logic [IDX_W-1:0] base_idx, base_val, cur_idx;
    logic             stop_req, clr_halt, base_load;
    logic [15:0]      rd_status, wr_status;
    logic [BUF_AW-1:0] rd_ptr;
    logic             eng_we;
    logic [LEN_W-1:0] wr_len;

    rxbd_ctl_regs #(.NDESC(NDESC), .MAXLEN_RST(MAXLEN_RST), .IDX_W(IDX_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .desc_we(desc_we), .desc_idx(desc_idx), .desc_hi(desc_hi), .desc_rdata(desc_rdata),
        .halted(halted), .busy_set(busy_set), .stop_set(stop_set),
        .maxlen(maxlen), .base_idx(base_idx), .stop_req(stop_req),
        .clr_halt(clr_halt), .base_load(base_load), .base_val(base_val)
    );

    rxbd_desc_table #(.NDESC(NDESC), .BUF_AW(BUF_AW), .IDX_W(IDX_W)) table_i (
        .clk(clk), .rst_n(rst_n),
        .sw_we(desc_we), .sw_idx(desc_idx), .sw_hi(desc_hi),
        .sw_wdata(sw_wdata), .sw_rdata(desc_rdata),
        .eng_idx(cur_idx), .eng_status(rd_status), .eng_ptr(rd_ptr),
        .eng_we(eng_we), .eng_wr_status(wr_status), .eng_wr_len(wr_len)
    );

    rxbd_fill_fsm #(.NDESC(NDESC), .BUF_AW(BUF_AW), .IDX_W(IDX_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_err(s_err), .s_ready(s_ready),
        .maxlen(maxlen), .base_idx(base_idx), .stop_req(stop_req),
        .clr_halt(clr_halt), .base_load(base_load), .base_val(base_val),
        .cur_idx(cur_idx), .rd_status(rd_status), .rd_ptr(rd_ptr),
        .desc_we(eng_we), .wr_status(wr_status), .wr_len(wr_len),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .busy_set(busy_set), .stop_set(stop_set), .halted(halted)
    );
endmodule

// File: tb/rxbd_ring_rx_tb_top.sv
module rxbd_ring_rx_tb_top;
    localparam int MAXL = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0, s_last = 1'b0, s_err = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_ready;
    logic        sw_wr = 1'b0;
    logic [7:0]  sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        buf_we;
    logic [15:0] buf_addr;
    logic [7:0]  buf_wdata;

    int total = 0, fails = 0, wr_count = 0;
    logic [7:0] bmem [0:1023];

    always #5 clk = ~clk;

    rxbd_ring_rx dut_i (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_err(s_err), .s_ready(s_ready),
        .sw_wr(sw_wr), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata)
    );

    always @(negedge clk) begin
        if (rst_n && buf_we) begin
            bmem[buf_addr[9:0]] = buf_wdata;
            wr_count = wr_count + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        total = total + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        sw_wr = 1'b1; sw_addr = a; sw_wdata = v;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        sw_addr = a;
        #1 v = sw_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sends n bytes, value seed+k; error flag on byte errb (or none if <0);
    // raises the stop control bit together with byte stopb (or never if <0)
    task automatic send(input int n, input int seed, input int errb, input int stopb);
        for (int k = 0; k < n; k++) begin
            int waitc;
            @(negedge clk);
            s_valid = 1'b1; s_data = 8'(seed + k); s_last = (k == n - 1); s_err = (k == errb);
            if (k == stopb) begin sw_wr = 1'b1; sw_addr = 8'h04; sw_wdata = 32'd1; end
            waitc = 0;
            #1;
            while (!s_ready && waitc < 50) begin
                @(negedge clk);
                if (sw_wr) sw_wr = 1'b0;
                #1;
                waitc++;
            end
            if (waitc >= 50) begin
                total = total + 1; fails = fails + 1;
                $display("FAIL R1 handshake timeout: actual ready 0 expected 1");
            end
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0; s_err = 1'b0; sw_wr = 1'b0;
    endtask

    task automatic arm(input int i, input bit wrap);
        wr(8'(8'h80 + 2 * i), {16'h8000 | (wrap ? 16'h2000 : 16'h0), 16'h0});
    endtask

    task automatic clear_region(input int p);
        for (int k = 0; k < 16; k++) bmem[p + k] = 8'hEE;
    endtask

    // checks entry i after a frame of n bytes with given seed
    task automatic check_entry(input string req, input int i, input int n, input int seed,
                               input bit wrap, input bit err, input int lim);
        logic [31:0] v;
        int exp_len, p;
        logic [15:0] exp_st;
        exp_len = (n > lim) ? lim : n;
        p = 16 + 64 * i;
        exp_st = 16'h0800 | (wrap ? 16'h2000 : 16'h0) | (err ? 16'h0002 : 16'h0) |
                 ((n > lim) ? 16'h0001 : 16'h0);
        rd(8'(8'h80 + 2 * i), v);
        chk(req, 32'(v[31:16]), 32'(exp_st), "status");  // R1 R2 R5 R6
        chk(req, 32'(v[15:0]), 32'(exp_len), "length");  // R4 R5
        for (int k = 0; k < exp_len; k++)
            if (bmem[p + k] !== 8'(seed + k)) begin
                chk(req, 32'(bmem[p + k]), 32'(8'(seed + k)), "buffer byte");  // R3
            end
        total = total + 1;  // R3 byte image checked as one
        chk(req, 32'(bmem[p + exp_len]), 32'hEE, "byte past end");  // R3 R5
        total = total - 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total = total + 1; fails = fails + 1;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int wc;
        for (int k = 0; k < 1024; k++) bmem[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10", 32'(s_ready), 0, "ready after reset");
        rd(8'h00, v); chk("R10", v, 0, "events after reset");
        rd(8'h01, v); chk("R10", v, 0, "halted after reset");

        wr(8'h03, MAXL);
        for (int i = 0; i < 4; i++) begin
            wr(8'(8'h81 + 2 * i), 32'(16 + 64 * i));
            arm(i, i == 3);
        end
        rd(8'h83, v); chk("R1", v, 32'd80, "pointer readback");

        // R10: first frame lands in entry 0; sweep lengths 1..12 around the limit
        for (int n = 1; n <= 12; n++) begin
            int i;
            bit e;
            i = (n - 1) % 4;
            e = (n % 5 == 0);
            clear_region(16 + 64 * i);
            send(n, n * 16, e ? n / 2 : -1, -1);
            idle(3);
            check_entry(n > MAXL ? "R5" : (e ? "R6" : "R4"), i, n, n * 16, i == 3, e, MAXL);
            arm(i, i == 3);
        end

        // R2: base register moves the ring start
        wr(8'h02, 32'd2);
        clear_region(16 + 64 * 2);
        send(6, 8'h30, -1, -1); idle(3);
        check_entry("R2", 2, 6, 8'h30, 1'b0, 1'b0, MAXL); arm(2, 1'b0);
        clear_region(16 + 64 * 3);
        send(5, 8'h50, -1, -1); idle(3);
        check_entry("R2", 3, 5, 8'h50, 1'b1, 1'b0, MAXL); arm(3, 1'b1);
        clear_region(16 + 64 * 2);
        send(7, 8'h70, -1, -1); idle(3);
        check_entry("R2", 2, 7, 8'h70, 1'b0, 1'b0, MAXL); arm(2, 1'b0);

        // R7: current entry (3) held by software
        wr(8'h86, 32'h0000_0000);
        wc = wr_count;
        send(5, 8'h90, -1, -1); idle(3);
        rd(8'h00, v); chk("R7", v & 32'h1, 1, "busy event");
        rd(8'h01, v); chk("R7", v, 1, "halted flag");
        chk("R7", 32'(wr_count), 32'(wc), "no buffer write");
        rd(8'h86, v); chk("R7", v, 0, "entry untouched");
        // R8: next frame also dropped, W1C semantics
        send(4, 8'hA0, -1, -1); idle(3);
        chk("R8", 32'(wr_count), 32'(wc), "dropped while halted");
        rd(8'h01, v); chk("R8", v, 1, "still halted");
        wr(8'h00, 32'h0);
        rd(8'h00, v); chk("R8", v & 32'h1, 1, "write 0 keeps event");
        wr(8'h00, 32'h1);
        rd(8'h00, v); chk("R8", v & 32'h1, 0, "write 1 clears event");
        arm(3, 1'b1);
        wr(8'h01, 32'h1);
        idle(3);
        rd(8'h01, v); chk("R8", v, 0, "resumed");
        clear_region(16 + 64 * 3);
        send(4, 8'hB0, -1, -1); idle(3);
        check_entry("R8", 3, 4, 8'hB0, 1'b1, 1'b0, MAXL); arm(3, 1'b1);

        // R9: graceful stop during a frame into entry 2
        clear_region(16 + 64 * 2);
        send(6, 8'hC0, -1, 2); idle(3);
        check_entry("R9", 2, 6, 8'hC0, 1'b0, 1'b0, MAXL); arm(2, 1'b0);
        rd(8'h00, v); chk("R9", v & 32'h2, 2, "stop-complete event");
        @(negedge clk);
        s_valid = 1'b1; s_data = 8'h11; s_last = 1'b1;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            #1 if (s_ready) chk("R9", 32'(s_ready), 0, "ready while stopped");
        end
        total = total + 1;
        s_valid = 1'b0; s_last = 1'b0;
        chk("R9", 32'(wr_count - wc), 32'd10, "writes before stop");
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h2);
        rd(8'h00, v); chk("R9", v & 32'h2, 0, "stop event cleared");
        clear_region(16 + 64 * 3);
        send(3, 8'hD0, -1, -1); idle(3);
        check_entry("R9", 3, 3, 8'hD0, 1'b1, 1'b0, MAXL);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule